// File: doc/BRIEF.md
# Pattern-Table Half Selector for Automatic CHR-RAM Switching

This block sits on the picture-processor side of a cartridge and decides which 4 KiB half of an 8 KiB CHR-RAM answers a pattern-table access. It watches three address lines of the picture bus. A13 tells nametable space from pattern space. A12 is the normal half select. A9 tells the upper half of a nametable from the lower half. It also drives the RAM enable for reads and writes that fall in pattern space (A13 low).

With the automatic mode bit cleared, the RAM's A12 simply follows the bus A12. With the bit set, the block captures bus A9 each time A13 goes from low to high, which is the start of a nametable fetch. It then drives that captured value as the RAM's A12 on every later pattern access. Tiles from the upper half of any nametable therefore come from the left pattern table, and tiles from the lower half come from the right one, whatever the scroll position. The mode bit comes from a CPU-side register file that lies outside this block. That bit is cleared by reset.

The bus is sampled on a system clock that runs faster than the picture-bus address rate. Both outputs are registered and appear one clock after the inputs that cause them.

Top module: `chr_half_switch`

## Requirements
- R1: A synchronous active-high reset clears the captured A9 value, the A13 sample and both outputs to 0. After reset, a pattern access in automatic mode selects half 0 until the first A13 rise.
- R2: With `auto_en` at 0 during a sampled cycle, `chr_a12` in the following cycle equals the `ppu_addr[12]` of that cycle.
- R3: With `auto_en` at 1 and `ppu_addr[13]` at 0 during a sampled cycle, `chr_a12` in the following cycle equals the `ppu_addr[9]` that was sampled on the most recent cycle in which `ppu_addr[13]` was 1 after a sample at 0.
- R4: The captured value changes only on a sampled 0-to-1 step of `ppu_addr[13]`. Later changes of A9 while A13 stays high have no effect on the half selected by the next pattern access.
- R5: In a cycle where `ppu_addr[13]` is 1, `chr_a12` in the following cycle equals `ppu_addr[12]`, whatever `auto_en` is.
- R6: `chr_ce` is 1 in the cycle after a cycle in which `ppu_addr[13]` is 0 and either `ppu_rd` or `ppu_wr` is 1. Otherwise it is 0.
- R7: Capture goes on while `auto_en` is 0. Setting `auto_en` uses the A9 value from the most recent A13 rise, even if that rise happened while the mode was off.
- R8: Changing `auto_en` between two pattern accesses changes the selection starting with the very next access, and leaves the captured value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the picture-bus address rate |
| rst | input | 1 | Synchronous active-high reset |
| ppu_addr | input | 14 | Picture-bus address |
| ppu_rd | input | 1 | Picture-bus read strobe, active high |
| ppu_wr | input | 1 | Picture-bus write strobe, active high |
| auto_en | input | 1 | Automatic half-switch mode bit from the register file |
| chr_a12 | output | 1 | Registered A12 for the CHR-RAM |
| chr_ce | output | 1 | Registered CHR-RAM enable |

## Verification
The hardest case to reach from the ports is a captured value that differs from what a fresh nametable fetch would give. Examples are A9 changing while A13 stays high, and a rise taken while the mode was off and only used after the mode is turned on. The directed stimulus holds A13 high across several addresses with different A9 values. It also toggles `auto_en` between a nametable fetch and the pattern fetches that follow it. A long random run then mixes A13 runs of different lengths with mode flips, and every clock is compared against a behavioural model.

// File: rtl/chr_sw_pkg.sv
package chr_sw_pkg;
  localparam int PPU_AW   = 14;
  localparam int TBL_BIT  = 13;
  localparam int HALF_BIT = 12;
  localparam int ROW_BIT  = 9;

  typedef struct packed {
    logic a12;
    logic ce;
  } chr_out_t;
endpackage

// File: rtl/chr_a13_edge.sv
module chr_a13_edge (
  input  logic clk,
  input  logic rst,
  input  logic tbl_bit,
  output logic tbl_q,
  output logic rise
);
  always_ff @(posedge clk) begin
    if (rst) tbl_q <= 1'b0;
    else     tbl_q <= tbl_bit;
  end

  assign rise = tbl_bit & ~tbl_q;
endmodule

// File: rtl/chr_row_latch.sv
module chr_row_latch (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic row_bit,
  output logic row_lat
);
  always_ff @(posedge clk) begin
    if (rst)          row_lat <= 1'b0;
    else if (capture) row_lat <= row_bit;
  end
endmodule

// File: rtl/chr_out_stage.sv
module chr_out_stage
  import chr_sw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tbl_bit,
  input  logic     half_bit,
  input  logic     row_lat,
  input  logic     auto_en,
  input  logic     access,
  output chr_out_t out_q
);
  chr_out_t out_d;

  always_comb begin
    out_d.a12 = (auto_en && !tbl_bit) ? row_lat : half_bit;
    out_d.ce  = access && !tbl_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= out_d;
  end
endmodule

// File: rtl/chr_half_switch.sv
module chr_half_switch
  import chr_sw_pkg::*;
#(
  parameter int AW = PPU_AW,
  parameter int TB = TBL_BIT,
  parameter int HB = HALF_BIT,
  parameter int RB = ROW_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ppu_addr,
  input  logic          ppu_rd,
  input  logic          ppu_wr,
  input  logic          auto_en,
  output logic          chr_a12,
  output logic          chr_ce
);
  logic     tbl_q;
  logic     rise;
  logic     row_lat;
  chr_out_t out_q;

  chr_a13_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .tbl_bit (ppu_addr[TB]),
    .tbl_q   (tbl_q),
    .rise    (rise)
  );

  chr_row_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .capture (rise),
    .row_bit (ppu_addr[RB]),
    .row_lat (row_lat)
  );

  chr_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .tbl_bit  (ppu_addr[TB]),
    .half_bit (ppu_addr[HB]),
    .row_lat  (row_lat),
    .auto_en  (auto_en),
    .access   (ppu_rd | ppu_wr),
    .out_q    (out_q)
  );

  assign chr_a12 = out_q.a12;
  assign chr_ce  = out_q.ce;
endmodule

// File: rtl/chr_half_switch_checks.sv
module chr_half_switch_checks #(
  parameter int AW = 14,
  parameter int TB = 13,
  parameter int HB = 12,
  parameter int RB = 9
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] ppu_addr,
  input logic          ppu_rd,
  input logic          ppu_wr,
  input logic          auto_en,
  input logic          chr_a12,
  input logic          chr_ce,
  input logic          tbl_q,
  input logic          row_lat
);
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!chr_a12 && !chr_ce && !row_lat && !tbl_q));

  p_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (live && $past(!auto_en)) |-> (chr_a12 == $past(ppu_addr[HB])));

  p_auto_r3: assert property (@(posedge clk) disable iff (rst)
    (live && $past(auto_en && !ppu_addr[TB])) |-> (chr_a12 == $past(row_lat)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (live && $past(tbl_q) && $past(ppu_addr[TB])) |-> $stable(row_lat));

  p_ntab_r5: assert property (@(posedge clk) disable iff (rst)
    (live && $past(ppu_addr[TB])) |-> (chr_a12 == $past(ppu_addr[HB]) && !chr_ce));

  p_ce_r6: assert property (@(posedge clk) disable iff (rst)
    live |-> (chr_ce == $past(!ppu_addr[TB] && (ppu_rd || ppu_wr))));
endmodule

bind chr_half_switch chr_half_switch_checks #(
  .AW(AW), .TB(TB), .HB(HB), .RB(RB)
) u_checks (
  .clk      (clk),
  .rst      (rst),
  .ppu_addr (ppu_addr),
  .ppu_rd   (ppu_rd),
  .ppu_wr   (ppu_wr),
  .auto_en  (auto_en),
  .chr_a12  (chr_a12),
  .chr_ce   (chr_ce),
  .tbl_q    (tbl_q),
  .row_lat  (row_lat)
);

// File: tb/chr_half_switch_bench.sv
module chr_half_switch_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ppu_addr = '0;
  logic        ppu_rd = 1'b0;
  logic        ppu_wr = 1'b0;
  logic        auto_en = 1'b0;
  logic        chr_a12;
  logic        chr_ce;

  int checks = 0;
  int fails  = 0;

  int m_prev_hi = 0;
  int m_lat     = 0;
  int e_a12     = 0;
  int e_ce      = 0;
  string tag_a12 = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  chr_half_switch u_chr_half_switch (
    .clk(clk), .rst(rst), .ppu_addr(ppu_addr), .ppu_rd(ppu_rd),
    .ppu_wr(ppu_wr), .auto_en(auto_en), .chr_a12(chr_a12), .chr_ce(chr_ce)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, step the behavioural model, compare after the edge
  task automatic step(input int addr, input int rd, input int wr, input int en,
                      input string extra = "");
    int hi, a9, a12;
    ppu_addr = addr[13:0]; ppu_rd = rd[0]; ppu_wr = wr[0]; auto_en = en[0];
    hi = (addr >> 13) & 1; a9 = (addr >> 9) & 1; a12 = (addr >> 12) & 1;
    @(posedge clk); #1;
    if (en != 0 && hi == 0) begin e_a12 = m_lat; tag_a12 = "R3"; end
    else begin e_a12 = a12; tag_a12 = (hi != 0) ? "R5" : "R2"; end
    e_ce = (hi == 0 && (rd != 0 || wr != 0)) ? 1 : 0;
    if (hi != 0 && m_prev_hi == 0) m_lat = a9;
    m_prev_hi = hi;
    @(negedge clk);
    check({tag_a12, extra}, chr_a12, e_a12);
    check("R6", chr_ce, e_ce);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", chr_a12, 0);
    check("R1", chr_ce, 0);
    rst = 1'b0;
    // R1: latch starts at 0, automatic mode selects half 0 with A12 high
    step(14'h1000, 1, 0, 1, " R1");
    // R2: mode off follows A12
    step(14'h1000, 1, 0, 0);
    step(14'h0000, 1, 0, 0);
    step(14'h1FFF, 0, 1, 0);
    // R3: nametable fetch in lower half, then pattern fetches
    step(14'h2200, 1, 0, 1);
    step(14'h0010, 1, 0, 1);
    step(14'h0020, 0, 0, 1);
    // R4: A9 changes while A13 stays high are ignored
    step(14'h2000, 1, 0, 1);
    step(14'h2200, 1, 0, 1, " R4");
    step(14'h2200, 1, 0, 1, " R4");
    step(14'h1000, 1, 0, 1, " R4");
    // R7: capture while mode off, used after mode on
    step(14'h2300, 1, 0, 0, " R7");
    step(14'h0000, 1, 0, 0, " R7");
    step(14'h0000, 1, 0, 1, " R7");
    // R8: flip mode between pattern accesses
    step(14'h1000, 1, 0, 0, " R8");
    step(14'h0000, 1, 0, 1, " R8");
    step(14'h0000, 0, 1, 0, " R8");
    step(14'h1000, 0, 1, 1, " R8");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int a;
      a = $urandom_range(0, 16383);
      if ($urandom_range(0, 2) == 0) a = a | 14'h2000;
      step(a, $urandom_range(0, 1), $urandom_range(0, 1),
           ($urandom_range(0, 7) != 0) ? 1 : 0);
    end
    // reset again mid-run: R1
    rst = 1'b1;
    @(posedge clk); #1; m_lat = 0; m_prev_hi = 0;
    @(negedge clk);
    check("R1", chr_a12, 0);
    check("R1", chr_ce, 0);
    rst = 1'b0;
    step(14'h1000, 1, 0, 1, " R1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule